// File: doc/BRIEF.md
# Interrupt Claim Controller

This block collects level-sensitive interrupt requests from a set of numbered sources and drives one interrupt line to each processor context. Software programs a priority for each source, an enable mask for each context and a priority threshold for each context through a 32-bit register port. A context's line is raised while some source is pending, enabled for that context and above the context's threshold.

Software services an interrupt in two steps. It reads the context's claim register, which returns the best eligible source ID and takes that source out of the pending set. After the handler is done, it writes the same ID back to that register. Between the claim and the completion, the source's gateway ignores its input. After the completion, a request that is still asserted becomes pending again. Source ID 0 is reserved, so a claim that returns 0 means nothing is waiting.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, every claim read returns 0 and every `irq_o` bit is low.
- R2: A read issued with `re_i` returns its data on `rdata_o` with `rvalid_o` high on the next cycle. `rvalid_o` is low in cycles that do not follow a read. A priority register keeps only the low PW bits of the written data, and PW is 3 by default.
- R3: Register locations are fixed by byte address.
  - The priority of source n is at n*4.
  - The threshold of context h is at 0x200000 + h*0x1000.
  - The claim/complete register of context h sits 4 bytes above that threshold.
  - Enables for context h use words at 0x2000 + h*0x80 + 4*(n/32), and source n maps to bit n mod 32 of its word.
- R4: Source 0 is reserved, so its priority address and enable bit 0 read 0 and ignore writes. Enable bits above the source count read 0. Addresses that map to nothing read 0 and ignore writes.
- R5: `irq_o[h]` is high exactly when some source is pending, enabled for context h and has a priority strictly above context h's threshold.
- R6: A source with priority 0 is never delivered or claimed. Setting its priority back to a nonzero value makes it eligible again.
- R7: A claim read returns the eligible source with the highest priority, picking the lowest ID on a tie, or 0 when no source is eligible.
- R8: A claim clears the pending state of the returned source. That source's input is then ignored until the source is completed.
- R9: Writing a claimed source's ID to the claim/complete register completes it. A still-asserted input then becomes pending again, and the line rises two cycles after the write.
- R10: A completion naming a source that is not currently claimed has no effect.
- R11: Each context has its own enables and threshold, but all contexts share pending state. A claim from one context removes the source from every context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; a read of a claim register also performs the claim |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | High the cycle after a read |
| src_i | input | NSRC | Level interrupt requests for sources 1 to NSRC |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
A corrupted pending or claimed bit shows up on the context line in the cycle right after the offending edge. A source that is wrongly left pending keeps `irq_o` high after its claim. A gateway that fails to reopen keeps the line low two cycles after a completion. A bad arbitration or threshold compare shows up in the ID returned by the very next claim read. The bench therefore probes each line and each claim value right after every state-changing access, and does not wait for a later symptom.

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 22
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [31:0]     rdata_o,
  output logic            rvalid_o,
  input  logic [NSRC:1]   src_i,
  output logic [NCTX-1:0] irq_o
);
  localparam int IW = $clog2(NSRC + 1);

  function automatic logic [AW-1:0] a_prio(int n);
    return AW'(n * 4);
  endfunction
  function automatic logic [AW-1:0] a_en(int h, int n);
    return AW'(32'h2000 + h * 32'h80 + 4 * (n / 32));
  endfunction
  function automatic logic [AW-1:0] a_thr(int h);
    return AW'(32'h200000 + h * 32'h1000);
  endfunction
  function automatic logic [AW-1:0] a_clm(int h);
    return AW'(32'h200004 + h * 32'h1000);
  endfunction

  logic [PW-1:0] prio_q [NSRC:1];
  logic [NSRC:1] en_q   [NCTX];
  logic [PW-1:0] thr_q  [NCTX];
  logic [NSRC:1] pend_q, infl_q;
  logic [IW-1:0] best_id [NCTX];

  logic [31:0]   rd_d;
  logic          clm_hit, cpl_hit;
  logic [IW-1:0] clm_id;
  logic          clm_take;

  always_comb begin
    for (int h = 0; h < NCTX; h++) begin : arb
      logic [PW-1:0] bp;
      logic [IW-1:0] bi;
      bp = thr_q[h];
      bi = '0;
      for (int n = 1; n <= NSRC; n++)
        if (pend_q[n] && en_q[h][n] && prio_q[n] > bp) begin
          bp = prio_q[n];
          bi = IW'(n);
        end
      best_id[h] = bi;
    end
  end

  for (genvar h = 0; h < NCTX; h++) begin : g_irq
    assign irq_o[h] = |best_id[h];
  end

  always_comb begin
    rd_d    = '0;
    clm_hit = 1'b0;
    cpl_hit = 1'b0;
    clm_id  = '0;
    for (int n = 1; n <= NSRC; n++)
      if (addr_i == a_prio(n)) rd_d = 32'(prio_q[n]);
    for (int h = 0; h < NCTX; h++) begin
      for (int n = 1; n <= NSRC; n++)
        if (addr_i == a_en(h, n)) rd_d[n % 32] = en_q[h][n];
      if (addr_i == a_thr(h)) rd_d = 32'(thr_q[h]);
      if (addr_i == a_clm(h)) begin
        rd_d    = 32'(best_id[h]);
        clm_id  = best_id[h];
        clm_hit = re_i;
        cpl_hit = we_i;
      end
    end
  end

  assign clm_take = clm_hit && (clm_id != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 1; n <= NSRC; n++) prio_q[n] <= '0;
      for (int h = 0; h < NCTX; h++) begin
        en_q[h]  <= '0;
        thr_q[h] <= '0;
      end
    end else if (we_i) begin
      for (int n = 1; n <= NSRC; n++)
        if (addr_i == a_prio(n)) prio_q[n] <= wdata_i[PW-1:0];
      for (int h = 0; h < NCTX; h++) begin
        for (int n = 1; n <= NSRC; n++)
          if (addr_i == a_en(h, n)) en_q[h][n] <= wdata_i[n % 32];
        if (addr_i == a_thr(h)) thr_q[h] <= wdata_i[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      infl_q <= '0;
    end else begin
      for (int n = 1; n <= NSRC; n++) begin
        if (clm_take && clm_id == IW'(n)) begin
          pend_q[n] <= 1'b0;
          infl_q[n] <= 1'b1;
        end else if (!pend_q[n] && !infl_q[n] && src_i[n]) begin
          pend_q[n] <= 1'b1;
        end
        if (cpl_hit && wdata_i == 32'(n) && infl_q[n]) infl_q[n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 22
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            re_i,
  input logic [31:0]     rdata_o,
  input logic            rvalid_o,
  input logic [NCTX-1:0] irq_o,
  input logic [NSRC:1]   pend_q,
  input logic [NSRC:1]   infl_q,
  input logic [NSRC:1]   en_q [NCTX],
  input logic [PW-1:0]   prio_q [NSRC:1]
);
  localparam int IW = $clog2(NSRC + 1);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o); // R2
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == '0) |=> rdata_o == '0); // R4
  AST_GATE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & infl_q) == '0); // R8

  for (genvar h = 0; h < NCTX; h++) begin : g_ctx
    localparam logic [AW-1:0] CA = AW'(32'h200004 + 32'(h) * 32'h1000);
    AST_LINE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[h] |-> (pend_q & en_q[h]) != '0); // R5
    AST_CLAIM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i == CA) |=> rdata_o <= 32'(NSRC)); // R7
    AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i == CA && irq_o[h]) |=>
        (rdata_o != '0 && rdata_o <= 32'(NSRC) &&
         !pend_q[rdata_o[IW-1:0]] && infl_q[rdata_o[IW-1:0]])); // R8
    for (genvar n = 1; n <= NSRC; n++) begin : g_src
      AST_PRIO_ZERO_NOT_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && addr_i == CA && prio_q[n] == '0) |=> rdata_o != 32'(n)); // R6
    end
  end
endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .re_i(re_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o),
  .pend_q(pend_q), .infl_q(infl_q), .en_q(en_q), .prio_q(prio_q)
);

// File: tb/irq_claim_ctrl_bench.sv
module irq_claim_ctrl_bench;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam logic [21:0] THR0 = 22'h200000, CLM0 = 22'h200004;
  localparam logic [21:0] THR1 = 22'h201000, CLM1 = 22'h201004;
  localparam logic [21:0] EN0 = 22'h2000, EN1 = 22'h2080;

  logic clk = 0, rst_n = 0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 0, re = 0;
  logic [31:0] rdata;
  logic rvalid;
  logic [NSRC:1] src = '0;
  logic [NCTX-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_claim_ctrl u_irq_claim_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .rvalid_o(rvalid), .src_i(src), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data act=%h exp=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [21:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; re = 1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    re = 0;
  endtask

  task automatic chk_irq(input int h, input logic e, input string t);
    checks++;
    if (irq[h] !== e) begin
      errors++;
      $display("FAIL %s irq[%0d] act=%b exp=%b", t, h, irq[h], e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk_irq(0, 0, "R1"); chk_irq(1, 0, "R1");
    rd(22'h4, 0, "R1");
    rd(EN0, 0, "R1");
    rd(THR0, 0, "R1");
    rd(CLM0, 0, "R1");
    // R2 R3 priority storage and width
    wr(22'hC, 5); rd(22'hC, 5, "R2");
    wr(22'hC, 32'hFF); rd(22'hC, 7, "R2");
    // R4 reserved source, unmapped, out-of-range enable bits
    wr(22'h0, 7); rd(22'h0, 0, "R4");
    wr(EN0, 32'hFFFF_FFFF); rd(EN0, 32'hFFFF_FFFE, "R4");
    wr(22'h1000, 32'h1234); rd(22'h1000, 0, "R4");
    rd(22'h2004, 0, "R4");
    // R7 ties go to lowest ID
    wr(EN0, 32'hA8);
    rd(EN0, 32'hA8, "R3");
    wr(22'hC, 2); wr(22'h14, 2); wr(22'h1C, 1);
    src[3] = 1; src[5] = 1; src[7] = 1;
    idle(1);
    chk_irq(0, 1, "R5"); chk_irq(1, 0, "R11");
    rd(CLM0, 3, "R7");
    chk_irq(0, 1, "R8");
    rd(CLM0, 5, "R7");
    rd(CLM0, 7, "R7");
    rd(CLM0, 0, "R8");
    chk_irq(0, 0, "R8");
    idle(3);
    chk_irq(0, 0, "R8");
    // R9 completion re-arms a held input
    wr(CLM0, 3);
    idle(1);
    chk_irq(0, 1, "R9");
    rd(CLM0, 3, "R9");
    // R7 priority beats ID; R5 threshold gate
    wr(CLM0, 5); wr(CLM0, 7);
    idle(1);
    wr(22'h1C, 4);
    rd(CLM0, 7, "R7");
    wr(THR0, 2); chk_irq(0, 0, "R5");
    rd(THR0, 2, "R3");
    wr(THR0, 1); chk_irq(0, 1, "R5");
    rd(CLM0, 5, "R7");
    wr(THR0, 0);
    // R6 priority zero masks
    wr(CLM0, 5);
    idle(1);
    chk_irq(0, 1, "R6");
    wr(22'h14, 0); chk_irq(0, 0, "R6");
    rd(CLM0, 0, "R6");
    wr(22'h14, 1); chk_irq(0, 1, "R6");
    rd(CLM0, 5, "R6");
    // R10 stray completions ignored
    wr(EN0, 32'h2A8); wr(22'h24, 3);
    src[9] = 1;
    idle(1);
    chk_irq(0, 1, "R10");
    wr(CLM0, 9);
    rd(CLM0, 9, "R10");
    wr(CLM0, 10);
    idle(2);
    chk_irq(0, 0, "R10");
    wr(CLM0, 9);
    idle(1);
    chk_irq(0, 1, "R9");
    // R11 second context
    rd(THR1, 0, "R11");
    wr(EN1, 32'h200);
    rd(EN1, 32'h200, "R11");
    chk_irq(1, 1, "R11");
    rd(CLM1, 9, "R11");
    chk_irq(0, 0, "R11"); chk_irq(1, 0, "R11");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 reads outstanding act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule